// File: doc/BRIEF.md
# Staggered Half-Warp Issue Unit

This block feeds 32-lane warp instructions into a set of execution pipelines that are each only 16 lanes wide. Every accepted instruction is played out on its chosen pipeline as two beats on consecutive cycles. The first beat carries lanes 0 to 15 and the second carries lanes 16 to 31. While one pipeline is on its second beat, the issue stage is free to start another instruction on any other pipeline. Two pipelines therefore overlap: one works on the upper half of one warp while another works on the lower half of a different warp.

The instruction source offers one instruction per cycle with a valid/ready handshake. The instruction carries a pipeline selector, a warp ID, a tag and the full 32-lane operand bundle. The source guarantees that operands are ready, so the block tracks no dependencies. An instruction aimed at a pipeline that is on its first beat is held back for exactly one cycle. A pipeline on its second beat can take a new instruction, so a single pipeline sustains one instruction every two cycles.

Top module: `half_warp_issue`

## Requirements
- R1: A synchronous active-high reset clears every pipeline's beat-valid and half flag. After reset, `in_ready` is 1 for every selector value.
- R2: When `in_valid && in_ready` at a clock edge, the pipeline whose index equals `in_pipe` presents, in the next cycle, `out_valid`=1 and `out_half`=0. It also presents the instruction's warp ID and tag, and operand lanes 0..15. Lane i of `in_operands` sits at bits [i*LANE_W +: LANE_W], and lane j of a beat sits at bits [j*LANE_W +: LANE_W] of that pipeline's `out_lanes` slice.
- R3: In the cycle after a lower beat, the same pipeline presents `out_half`=1 with the same warp ID and tag and operand lanes 16..31.
- R4: After an upper beat, the pipeline's `out_valid` drops to 0 unless a new instruction was accepted for it in that same cycle.
- R5: An instruction affects only the selected pipeline. Every other pipeline's outputs follow their own sequence.
- R6: While the pipeline selected by `in_pipe` shows a lower beat, `in_ready` is 0 and no instruction is accepted. The stall lasts one cycle.
- R7: A pipeline that shows an upper beat accepts a new instruction. The new instruction's lower beat follows in the very next cycle, with no idle cycle between them.
- R8: Instructions aimed at different pipelines are accepted on consecutive cycles, so two pipelines are active in the same cycle.
- R9: With `in_valid`=0, no pipeline starts a new instruction. Running beats still complete.
- R10: At most one instruction is accepted per cycle. `in_pipe` is a 2-bit binary index in which value k selects output slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_pipe | input | SEL_W (2) | Target pipeline index |
| in_warp | input | WID_W | Warp ID |
| in_tag | input | TAG_W | Instruction tag |
| in_operands | input | WARP_LANES*LANE_W | Full warp operand bundle |
| out_valid | output | NUM_PIPES | Per-pipeline beat valid |
| out_half | output | NUM_PIPES | Per-pipeline half marker, 0 lower, 1 upper |
| out_warp | output | NUM_PIPES*WID_W | Per-pipeline warp ID |
| out_tag | output | NUM_PIPES*TAG_W | Per-pipeline tag |
| out_lanes | output | NUM_PIPES*WARP_LANES/2*LANE_W | Per-pipeline 16-lane beat data |

## Verification
Each pipeline slot holds a small amount of state: a valid bit, a half bit and a captured bundle. Any corruption of that state reaches the ports within one cycle. A stuck half bit shows as a missing upper beat or a repeated lower beat. A wrong busy view shows as `in_ready` being wrong for the selector being offered. A mis-sliced bundle shows as wrong lanes in the very beat that follows. The bench sweeps every ordered pair of pipelines at every issue gap, then runs a long pseudo-random stream. It compares ready and all four slots against an arithmetic model on every cycle, so any divergence is caught on the first cycle it appears.

// File: rtl/half_issue_pkg.sv
package half_issue_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_LOWER = 2'd1,
    SLOT_UPPER = 2'd2
  } slot_phase_e;

  // One-hot decode of a binary pipeline index; out-of-range gives zero.
  function automatic logic [31:0] pipe_onehot(input int unsigned idx, input int unsigned npipes);
    logic [31:0] r;
    r = '0;
    if (idx < npipes) r[idx] = 1'b1;
    return r;
  endfunction

  // Index of the first lane that belongs to the given half of a warp.
  function automatic int unsigned half_base_lane(input logic upper, input int unsigned warp_lanes);
    return upper ? warp_lanes / 2 : 0;
  endfunction

  // Bit offset of a lane inside a packed bundle.
  function automatic int unsigned lane_offset(input int unsigned lane, input int unsigned lane_w);
    return lane * lane_w;
  endfunction

endpackage

// File: rtl/issue_gate.sv
module issue_gate #(
  parameter int NUM_PIPES = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 in_valid,
  input  logic [SEL_W-1:0]     in_pipe,
  input  logic [NUM_PIPES-1:0] pipe_lower_busy,
  output logic                 in_ready,
  output logic [NUM_PIPES-1:0] accept_vec
);
  import half_issue_pkg::*;

  logic [NUM_PIPES-1:0] sel_vec;
  logic                 sel_in_range;
  logic                 sel_busy;
  logic [31:0]          onehot_full;

  always_comb begin
    onehot_full  = pipe_onehot(int'(in_pipe), NUM_PIPES);
    sel_vec      = onehot_full[NUM_PIPES-1:0];
    sel_in_range = |sel_vec;
    sel_busy     = |(sel_vec & pipe_lower_busy);
  end

  // Ready depends only on the state of the targeted pipeline.
  assign in_ready   = sel_in_range && !sel_busy;
  assign accept_vec = (in_valid && in_ready) ? sel_vec : '0;

endmodule

// File: rtl/half_pipe_slot.sv
module half_pipe_slot #(
  parameter int WARP_LANES = 32,
  parameter int LANE_W     = 8,
  parameter int WID_W      = 4,
  parameter int TAG_W      = 4,
  localparam int HALF_LANES = WARP_LANES / 2,
  localparam int BUNDLE_W   = WARP_LANES * LANE_W,
  localparam int BEAT_W     = HALF_LANES * LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [WID_W-1:0]    load_warp,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic [BUNDLE_W-1:0] load_bundle,
  output logic                beat_valid,
  output logic                beat_half,
  output logic [WID_W-1:0]    beat_warp,
  output logic [TAG_W-1:0]    beat_tag,
  output logic [BEAT_W-1:0]   beat_lanes,
  output logic                lower_busy
);
  import half_issue_pkg::*;

  slot_phase_e         phase_q, phase_d;
  logic [WID_W-1:0]    warp_q;
  logic [TAG_W-1:0]    tag_q;
  logic [BUNDLE_W-1:0] bundle_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      SLOT_IDLE:  phase_d = load ? SLOT_LOWER : SLOT_IDLE;
      SLOT_LOWER: phase_d = SLOT_UPPER;
      SLOT_UPPER: phase_d = load ? SLOT_LOWER : SLOT_IDLE;
      default:    phase_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= SLOT_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  // Payload needs no reset: it is only observed while the slot is valid.
  always_ff @(posedge clk) begin
    if (load) begin
      warp_q   <= load_warp;
      tag_q    <= load_tag;
      bundle_q <= load_bundle;
    end
  end

  always_comb begin
    beat_lanes = '0;
    for (int j = 0; j < HALF_LANES; j++) begin
      beat_lanes[lane_offset(j, LANE_W) +: LANE_W] =
        bundle_q[lane_offset(half_base_lane(beat_half, WARP_LANES) + j, LANE_W) +: LANE_W];
    end
  end

  assign beat_valid = (phase_q != SLOT_IDLE);
  assign beat_half  = (phase_q == SLOT_UPPER);
  assign beat_warp  = warp_q;
  assign beat_tag   = tag_q;
  assign lower_busy = (phase_q == SLOT_LOWER);

endmodule

// File: rtl/half_warp_issue.sv
module half_warp_issue #(
  parameter int NUM_PIPES  = 4,
  parameter int WARP_LANES = 32,
  parameter int LANE_W     = 8,
  parameter int WID_W      = 4,
  parameter int TAG_W      = 4,
  localparam int SEL_W      = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int HALF_LANES = WARP_LANES / 2,
  localparam int BUNDLE_W   = WARP_LANES * LANE_W,
  localparam int BEAT_W     = HALF_LANES * LANE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [SEL_W-1:0]              in_pipe,
  input  logic [WID_W-1:0]              in_warp,
  input  logic [TAG_W-1:0]              in_tag,
  input  logic [BUNDLE_W-1:0]           in_operands,
  output logic [NUM_PIPES-1:0]          out_valid,
  output logic [NUM_PIPES-1:0]          out_half,
  output logic [NUM_PIPES*WID_W-1:0]    out_warp,
  output logic [NUM_PIPES*TAG_W-1:0]    out_tag,
  output logic [NUM_PIPES*BEAT_W-1:0]   out_lanes
);

  // Named internal events, observed by the bound checker.
  logic [NUM_PIPES-1:0] accept_vec;
  logic [NUM_PIPES-1:0] pipe_lower_busy;

  issue_gate #(
    .NUM_PIPES(NUM_PIPES),
    .SEL_W    (SEL_W)
  ) gate_i (
    .in_valid       (in_valid),
    .in_pipe        (in_pipe),
    .pipe_lower_busy(pipe_lower_busy),
    .in_ready       (in_ready),
    .accept_vec     (accept_vec)
  );

  for (genvar k = 0; k < NUM_PIPES; k++) begin : g_slot
    half_pipe_slot #(
      .WARP_LANES(WARP_LANES),
      .LANE_W    (LANE_W),
      .WID_W     (WID_W),
      .TAG_W     (TAG_W)
    ) slot_i (
      .clk        (clk),
      .rst        (rst),
      .load       (accept_vec[k]),
      .load_warp  (in_warp),
      .load_tag   (in_tag),
      .load_bundle(in_operands),
      .beat_valid (out_valid[k]),
      .beat_half  (out_half[k]),
      .beat_warp  (out_warp[k*WID_W +: WID_W]),
      .beat_tag   (out_tag[k*TAG_W +: TAG_W]),
      .beat_lanes (out_lanes[k*BEAT_W +: BEAT_W]),
      .lower_busy (pipe_lower_busy[k])
    );
  end

endmodule

// File: rtl/half_warp_issue_chk.sv
module half_warp_issue_chk #(
  parameter int NUM_PIPES = 4,
  parameter int SEL_W     = 2,
  parameter int WID_W     = 4,
  parameter int TAG_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [SEL_W-1:0]           in_pipe,
  input logic [NUM_PIPES-1:0]       out_valid,
  input logic [NUM_PIPES-1:0]       out_half,
  input logic [NUM_PIPES*WID_W-1:0] out_warp,
  input logic [NUM_PIPES*TAG_W-1:0] out_tag,
  input logic [NUM_PIPES-1:0]       accept_vec
);

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> out_valid == '0);

  assert_single_accept_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(accept_vec) <= 1);

  for (genvar k = 0; k < NUM_PIPES; k++) begin : g_pipe
    assert_accept_lower_R2: assert property (@(posedge clk) disable iff (rst)
      accept_vec[k] |=> out_valid[k] && !out_half[k]);

    assert_lower_then_upper_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] && !out_half[k] |=> out_valid[k] && out_half[k]
        && $stable(out_warp[k*WID_W +: WID_W]) && $stable(out_tag[k*TAG_W +: TAG_W]));

    assert_upper_retires_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] && out_half[k] && !accept_vec[k] |=> !out_valid[k]);

    assert_stall_on_lower_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid && (int'(in_pipe) == k) && out_valid[k] && !out_half[k] |-> !in_ready);

    assert_idle_input_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid && !out_valid[k] |=> !out_valid[k]);
  end

endmodule

bind half_warp_issue half_warp_issue_chk #(
  .NUM_PIPES(NUM_PIPES),
  .SEL_W    (SEL_W),
  .WID_W    (WID_W),
  .TAG_W    (TAG_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_pipe   (in_pipe),
  .out_valid (out_valid),
  .out_half  (out_half),
  .out_warp  (out_warp),
  .out_tag   (out_tag),
  .accept_vec(accept_vec)
);

// File: tb/half_warp_issue_tb_top.sv
module half_warp_issue_tb_top;
  localparam int NP = 4;
  localparam int WL = 32;
  localparam int LW = 8;
  localparam int WW = 4;
  localparam int TW = 4;
  localparam int HL = WL / 2;
  localparam int BW = WL * LW;
  localparam int EW = HL * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_pipe = '0;
  logic [WW-1:0] in_warp = '0;
  logic [TW-1:0] in_tag = '0;
  logic [BW-1:0] in_operands = '0;
  logic [NP-1:0] out_valid, out_half;
  logic [NP*WW-1:0] out_warp;
  logic [NP*TW-1:0] out_tag;
  logic [NP*EW-1:0] out_lanes;

  always #4 clk = ~clk;

  half_warp_issue dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pipe(in_pipe), .in_warp(in_warp), .in_tag(in_tag),
    .in_operands(in_operands), .out_valid(out_valid), .out_half(out_half),
    .out_warp(out_warp), .out_tag(out_tag), .out_lanes(out_lanes)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int seq      = 0;

  // Reference model state, one entry per pipeline.
  logic          m_valid [NP];
  logic          m_half  [NP];
  logic [WW-1:0] m_warp  [NP];
  logic [TW-1:0] m_tag   [NP];
  logic [BW-1:0] m_bundle[NP];

  function automatic logic [BW-1:0] make_bundle(input int seed);
    logic [BW-1:0] b;
    for (int i = 0; i < WL; i++) b[i*LW +: LW] = 8'((seed * 37) + (i * 5) + 1);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    for (int k = 0; k < NP; k++) begin
      logic [EW-1:0] exp_l;
      bit ok;
      for (int j = 0; j < HL; j++)
        exp_l[j*LW +: LW] = m_bundle[k][(j + (m_half[k] ? HL : 0))*LW +: LW];
      ok = (out_valid[k] == m_valid[k]);
      if (ok && m_valid[k])
        ok = (out_half[k] == m_half[k]) && (out_warp[k*WW +: WW] == m_warp[k])
          && (out_tag[k*TW +: TW] == m_tag[k]) && (out_lanes[k*EW +: EW] == exp_l);
      check(ok, req,
            {out_valid[k], out_half[k], out_warp[k*WW +: WW], out_tag[k*TW +: TW], out_lanes[k*EW +: EW]},
            {m_valid[k], m_half[k], m_warp[k], m_tag[k], exp_l});
    end
  endtask

  // Drive at the falling edge, check ready, advance the model, check outputs one cycle later.
  task automatic step(input bit v, input int p, output bit accepted);
    bit exp_ready;
    logic [BW-1:0] b;
    seq++;
    b = make_bundle(seq);
    in_valid = v; in_pipe = 2'(p); in_warp = WW'(seq); in_tag = TW'(seq * 3); in_operands = b;
    #1;
    exp_ready = !(m_valid[p] && !m_half[p]);
    check(in_ready == exp_ready, "R6 ready", 512'(in_ready), 512'(exp_ready));
    accepted = v && exp_ready;
    for (int k = 0; k < NP; k++) begin
      if (accepted && k == p) begin
        m_valid[k] = 1'b1; m_half[k] = 1'b0;
        m_warp[k] = WW'(seq); m_tag[k] = TW'(seq * 3); m_bundle[k] = b;
      end else if (m_valid[k] && !m_half[k]) begin
        m_half[k] = 1'b1;
      end else begin
        m_valid[k] = 1'b0;
      end
    end
    @(negedge clk);
    check_outputs("R2/R3/R4/R5");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit acc;
    logic [15:0] lfsr;
    for (int k = 0; k < NP; k++) begin
      m_valid[k] = 0; m_half[k] = 0; m_warp[k] = '0; m_tag[k] = '0; m_bundle[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(out_valid == '0, "R1 valid after reset", 512'(out_valid), 512'(0));
    for (int p = 0; p < NP; p++) begin
      in_pipe = 2'(p); #1;
      check(in_ready == 1'b1, "R1 ready after reset", 512'(in_ready), 512'(1));
    end
    // R9: idle input leaves everything idle
    for (int i = 0; i < 3; i++) step(1'b0, i % NP, acc);
    // R10 directed: selector value k drives slot k only
    for (int p = 0; p < NP; p++) begin
      step(1'b1, p, acc);
      check(acc && out_valid == NP'(1 << p), "R10 selector maps to slot", 512'(out_valid), 512'(1 << p));
      step(1'b0, 0, acc);
      step(1'b0, 0, acc);
    end
    // R7: back-to-back on the same pipe, one every two cycles
    step(1'b1, 2, acc);
    step(1'b1, 2, acc);
    check(!acc, "R6 stall on lower beat", 512'(acc), 512'(0));
    step(1'b1, 2, acc);
    check(acc && out_half[2] == 1'b0, "R7 reissue on upper beat", 512'(acc), 512'(1));
    step(1'b0, 0, acc); step(1'b0, 0, acc);
    // R8: consecutive issue to different pipes, overlap
    step(1'b1, 0, acc);
    step(1'b1, 1, acc);
    check(acc && out_valid[0] && out_half[0] && out_valid[1] && !out_half[1],
          "R8 two pipes overlap", 512'({out_valid, out_half}), 512'(8'b0011_0001));
    step(1'b0, 0, acc); step(1'b0, 0, acc);
    // Exhaustive pair sweep over pipes and gaps (R5/R7/R8)
    for (int a = 0; a < NP; a++)
      for (int b2 = 0; b2 < NP; b2++)
        for (int gap = 0; gap < 3; gap++) begin
          step(1'b1, a, acc);
          for (int g = 0; g < gap; g++) step(1'b0, 0, acc);
          acc = 0;
          for (int t = 0; t < 4 && !acc; t++) step(1'b1, b2, acc);
          for (int d = 0; d < 3; d++) step(1'b0, 0, acc);
        end
    // Pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], int'(lfsr[3:2]), acc);
    end
    // R1 again: reset mid-traffic clears all beats
    step(1'b1, 3, acc);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < NP; k++) begin m_valid[k] = 0; m_half[k] = 0; end
    check(out_valid == '0, "R1 reset mid-traffic", 512'(out_valid), 512'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule